// File: doc/BRIEF.md
# Dual-Section Ripple Decade Counter

This block is a 4-bit counter split into two sections that run from separate count inputs. The low section divides by two and drives bit 0 of the count. The high section divides by a fixed modulus (5, 6 or 8, chosen by a parameter) and drives bits 3 to 1 as a plain binary value. Each section moves one step when its count input goes from high to low.

The count inputs are slow external lines. A fast system clock samples them through a two-flop synchronizer, and a falling edge becomes a one-cycle step enable, so every register in the block sits on the system clock. The overall counting mode comes from wiring outside the block. Feeding bit 0 back into the high section's count input gives a decade, modulo-12 or modulo-16 count. Feeding bit 3 into the low section's count input gives a bi-quinary count.

Two pairs of control inputs override counting. When both inputs of the clear pair are high, the count goes to zero. In the modulus-5 variant, when both inputs of the nine pair are high, the count is forced to nine. The nine pair wins over the clear pair.

Top module: `dual_section_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `count_o` becomes 4'b0000.
- R2: Each high-to-low transition of `tick_a_i` flips `count_o[0]` exactly once, about three system clocks later. A rising transition or a steady level leaves it unchanged.
- R3: Each high-to-low transition of `tick_b_i` advances `count_o[3:1]` by one through the binary values 0 to MODULUS-1, then wraps to 0. `count_o[0]` is unaffected.
- R4: With MODULUS = 5 and `count_o[0]` wired to `tick_b_i`, the count on `count_o[3:0]` after n falling edges on `tick_a_i` is n mod 10.
- R5: With MODULUS = 5, `count_o[3]` wired to `tick_a_i` and edges applied to `tick_b_i`, the value {`count_o[0]`, `count_o[3:1]`} runs 0,1,2,3,4,8,9,10,11,12 and repeats.
- R6: With MODULUS = 6 and `count_o[0]` wired to `tick_b_i`, the count after n edges on `tick_a_i` is n mod 12.
- R7: With MODULUS = 8 and `count_o[0]` wired to `tick_b_i`, the count after n edges on `tick_a_i` is n mod 16.
- R8: When `clr_a_i` and `clr_b_i` are both high, `count_o` is 0 from the next `clk` edge on and stays 0 for as long as both are held. One input alone has no effect.
- R9: With MODULUS = 5, when `nine_a_i` and `nine_b_i` are both high, `count_o` becomes 4'b1001 on the next `clk` edge. One input alone has no effect. For any other modulus the pair is ignored.
- R10: When both control pairs are true, nine wins over clear. While either override holds, count-input edges do not change `count_o`.
- R11: A falling edge on a count input produces a step enable that lasts exactly one system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_a_i | input | 1 | Count input of the divide-by-two section (acts on falling edges) |
| tick_b_i | input | 1 | Count input of the divide-by-MODULUS section (acts on falling edges) |
| clr_a_i | input | 1 | Clear pair, first input |
| clr_b_i | input | 1 | Clear pair, second input |
| nine_a_i | input | 1 | Set-to-nine pair, first input |
| nine_b_i | input | 1 | Set-to-nine pair, second input |
| count_o | output | 4 | Counter value; bit 0 from the low section, bits 3:1 from the high section |

## Verification
The assertions assume that each count input holds every level for at least three system clocks, so the synchronizer sees each high and each low. They also assume that the control pairs are level inputs, set up before a `clk` edge. The stimulus holds each count level for ten cycles. That is longer than the six cycles a cascaded edge needs to pass through both synchronizers, so each check sees a settled count. The bench drives every input on the falling edge of `clk`. It holds each control pair for ten cycles, so any edge caused by the override on a wired-back output is absorbed while the override still holds.

// File: rtl/dsc_pkg.sv
// Package: shared definitions for the dual-section counter.
// Assumes: the high section always drives three output bits (Q3..Q1).
package dsc_pkg;

    // Width of the high section's output field.
    localparam int unsigned HI_W = 3;

    // Per-cycle command applied to both sections.
    typedef enum logic [1:0] {
        CTL_RUN   = 2'd0,
        CTL_CLEAR = 2'd1,
        CTL_NINE  = 2'd2
    } ctl_e;

    // Resolve the gated controls; nine wins over clear when allowed.
    function automatic ctl_e ctl_decode(
        input logic clr_a,
        input logic clr_b,
        input logic nine_a,
        input logic nine_b,
        input logic nine_ok
    );
        if (nine_ok && nine_a && nine_b) begin
            return CTL_NINE;
        end
        if (clr_a && clr_b) begin
            return CTL_CLEAR;
        end
        return CTL_RUN;
    endfunction

endpackage

// File: rtl/dsc_fall_detect.sv
// Module: synchronizes one slow count input and flags its falling edges.
// Assumes: the input holds each level for at least SYNC_STAGES+1 clk cycles.
// The chain resets low, so an input that is already high at reset gives no false edge.
module dsc_fall_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    // Keep the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // A step is "was high, now low".
    always_comb begin
        fall_o = prev_q & ~sync_q[LAST];
    end

    // R11: a step enable never lasts two cycles.
    assert_fall_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dsc_toggle_stage.sv
// Module: divide-by-two section driving bit 0 of the count.
// Assumes: step is a one-cycle enable; ctl is already priority-resolved.
module dsc_toggle_stage
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_e ctl,
    input  logic step,
    output logic q_o
);

    logic q_q;

    // Apply the override or flip on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= 1'b0;
        end else begin
            unique case (ctl)
                CTL_CLEAR: q_q <= 1'b0;
                CTL_NINE:  q_q <= 1'b1;
                default:   if (step) q_q <= ~q_q;
            endcase
        end
    end

    // Drive the section output.
    always_comb begin
        q_o = q_q;
    end

    // R2: a step in run mode changes the bit.
    assert_q0_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && step) |=> (q_o != $past(q_o)));
    // R2: without a step in run mode the bit holds.
    assert_q0_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && !step) |=> $stable(q_o));
    // R8: clear forces the bit low.
    assert_q0_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_CLEAR) |=> (q_o == 1'b0));

endmodule

// File: rtl/dsc_modn_stage.sv
// Module: divide-by-MODULUS section driving bits 3..1 as plain binary.
// Assumes: 2 <= MODULUS <= 8; nine is only requested when MODULUS is 5.
module dsc_modn_stage
    import dsc_pkg::*;
#(
    parameter int unsigned MODULUS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_e            ctl,
    input  logic            step,
    output logic [HI_W-1:0] q_o
);

    localparam logic [HI_W-1:0] TOP_VAL  = HI_W'(MODULUS - 1);
    localparam logic [HI_W-1:0] NINE_VAL = HI_W'(4);

    logic [HI_W-1:0] q_q;
    logic [HI_W-1:0] q_inc;

    // Next value in the wrapping binary sequence.
    always_comb begin
        q_inc = (q_q == TOP_VAL) ? '0 : q_q + 1'b1;
    end

    // Apply the override or advance on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            unique case (ctl)
                CTL_CLEAR: q_q <= '0;
                CTL_NINE:  q_q <= NINE_VAL;
                default:   if (step) q_q <= q_inc;
            endcase
        end
    end

    // Drive the section output.
    always_comb begin
        q_o = q_q;
    end

    // R3: the field never leaves 0..MODULUS-1.
    assert_b_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_o <= TOP_VAL);
    // R3: a step in run mode always moves the field.
    assert_b_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && step) |=> (q_o != $past(q_o)));
    // R3: no step in run mode, no movement.
    assert_b_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && !step) |=> $stable(q_o));
    // R8: clear empties the field.
    assert_b_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_CLEAR) |=> (q_o == '0));

endmodule

// File: rtl/dual_section_counter.sv
// Module: top of the dual-section counter; two synchronized count inputs,
// a divide-by-two section and a divide-by-MODULUS section, gated controls.
// Assumes: count inputs are slow relative to clk; the controls are level inputs.
module dual_section_counter
    import dsc_pkg::*;
#(
    parameter int unsigned SECOND_MOD  = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_a_i,
    input  logic       tick_b_i,
    input  logic       clr_a_i,
    input  logic       clr_b_i,
    input  logic       nine_a_i,
    input  logic       nine_b_i,
    output logic [3:0] count_o
);

    localparam int unsigned N_SECT   = 2;
    localparam logic        HAS_NINE = (SECOND_MOD == 5);

    logic [N_SECT-1:0] tick_raw;
    logic [N_SECT-1:0] tick_fall;
    ctl_e              ctl;
    logic              q_lo;
    logic [HI_W-1:0]   q_hi;

    // Gather the count inputs for the repeated edge detectors.
    always_comb begin
        tick_raw = {tick_b_i, tick_a_i};
    end

    // One synchronizer and edge detector per section.
    for (genvar s = 0; s < N_SECT; s++) begin : g_edge
        dsc_fall_detect #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_fall (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (tick_raw[s]),
            .fall_o (tick_fall[s])
        );
    end

    // Resolve the gated controls into one command.
    always_comb begin
        ctl = ctl_decode(clr_a_i, clr_b_i, nine_a_i, nine_b_i, HAS_NINE);
    end

    dsc_toggle_stage u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .step  (tick_fall[0]),
        .q_o   (q_lo)
    );

    dsc_modn_stage #(
        .MODULUS (SECOND_MOD)
    ) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .step  (tick_fall[1]),
        .q_o   (q_hi)
    );

    // Assemble the 4-bit count from both sections.
    always_comb begin
        count_o = {q_hi, q_lo};
    end

    // R9: a full nine request loads nine.
    assert_nine_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_NINE && nine_a_i && nine_b_i) |=> (count_o == 4'b1001));
    // R10: nine wins over a simultaneous clear.
    assert_nine_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_NINE && nine_a_i && nine_b_i && clr_a_i && clr_b_i) |=> (count_o == 4'b1001));
    // R8: a full clear without nine empties the count.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a_i && clr_b_i && !(HAS_NINE && nine_a_i && nine_b_i)) |=> (count_o == 4'b0000));

endmodule

// File: tb/dual_section_counter_tb.sv
// Bench: five instances wired for solo, decade, bi-quinary, mod-12 and mod-16 use.
module dual_section_counter_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_a = 1'b0, clr_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    logic ta_bcd = 1'b0, tb_bq = 1'b0, ta_m12 = 1'b0, ta_m16 = 1'b0;
    logic ta_solo = 1'b0, tb_solo = 1'b0;
    logic [3:0] q_bcd, q_bq, q_m12, q_m16, q_solo;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_section_counter #(.SECOND_MOD(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_a_i(ta_bcd), .tick_b_i(q_bcd[0]),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .count_o(q_bcd));
    dual_section_counter #(.SECOND_MOD(5)) u_bq (
        .clk(clk), .rst_n(rst_n), .tick_a_i(q_bq[3]), .tick_b_i(tb_bq),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .count_o(q_bq));
    dual_section_counter #(.SECOND_MOD(6)) u_m12 (
        .clk(clk), .rst_n(rst_n), .tick_a_i(ta_m12), .tick_b_i(q_m12[0]),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .count_o(q_m12));
    dual_section_counter #(.SECOND_MOD(8)) u_m16 (
        .clk(clk), .rst_n(rst_n), .tick_a_i(ta_m16), .tick_b_i(q_m16[0]),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .count_o(q_m16));
    dual_section_counter #(.SECOND_MOD(6)) u_solo (
        .clk(clk), .rst_n(rst_n), .tick_a_i(ta_solo), .tick_b_i(tb_solo),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .nine_a_i(nine_a), .nine_b_i(nine_b),
        .count_o(q_solo));

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_line(input int sel, input logic v);
        case (sel)
            0: ta_bcd = v;
            1: tb_bq = v;
            2: ta_m12 = v;
            3: ta_m16 = v;
            4: ta_solo = v;
            default: tb_solo = v;
        endcase
    endtask

    // One full pulse: ten cycles high, ten cycles low (cascade settles in six).
    task automatic pulse(input int sel);
        set_line(sel, 1'b1);
        wait_cyc(10);
        set_line(sel, 1'b0);
        wait_cyc(10);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1: every instance starts from zero.
        check(q_bcd, 4'd0, "R1 bcd");
        check(q_bq, 4'd0, "R1 bq");
        check(q_m12, 4'd0, "R1 m12");
        check(q_m16, 4'd0, "R1 m16");
        check(q_solo, 4'd0, "R1 solo");

        // R2: rising edge does nothing, falling edge flips bit 0.
        for (int n = 1; n <= 3; n++) begin
            ta_solo = 1'b1;
            wait_cyc(10);
            check(q_solo, 4'((n - 1) % 2), "R2 rising edge ignored");
            ta_solo = 1'b0;
            wait_cyc(10);
            check(q_solo, 4'(n % 2), "R2 falling edge toggles");
        end
        // R3: high section alone wraps at 6, bit 0 stays 1.
        for (int n = 1; n <= 8; n++) begin
            pulse(5);
            check(q_solo, 4'(((n % 6) * 2) + 1), "R3 solo high section");
        end

        // R4: decade count.
        for (int n = 1; n <= 25; n++) begin
            pulse(0);
            check(q_bcd, 4'(n % 10), "R4 bcd");
        end
        // R5: bi-quinary, read as {Q0,Q3,Q2,Q1}.
        for (int n = 1; n <= 25; n++) begin
            pulse(1);
            check({q_bq[0], q_bq[3:1]}, 4'(((n / 5) % 2) * 8 + (n % 5)), "R5 bi-quinary");
        end
        // R6: modulo 12.
        for (int n = 1; n <= 30; n++) begin
            pulse(2);
            check(q_m12, 4'(n % 12), "R6 mod12");
        end
        // R7: modulo 16.
        for (int n = 1; n <= 35; n++) begin
            pulse(3);
            check(q_m16, 4'(n % 16), "R7 mod16");
        end

        // R8: one clear input alone has no effect.
        clr_a = 1'b1;
        wait_cyc(10);
        check(q_bcd, 4'd5, "R8 single clear ignored bcd");
        check(q_m16, 4'd3, "R8 single clear ignored m16");
        // R8: both clear inputs empty every instance and hold it through edges.
        clr_b = 1'b1;
        wait_cyc(10);
        check(q_bcd, 4'd0, "R8 clear bcd");
        check(q_bq, 4'd0, "R8 clear bq");
        check(q_m16, 4'd0, "R8 clear m16");
        pulse(0);
        pulse(3);
        check(q_bcd, 4'd0, "R8 clear held bcd");
        check(q_m16, 4'd0, "R8 clear held m16");
        clr_a = 1'b0;
        clr_b = 1'b0;
        wait_cyc(10);

        // R9: one nine input alone has no effect.
        nine_a = 1'b1;
        wait_cyc(10);
        check(q_bcd, 4'd0, "R9 single nine ignored");
        // R9: both load nine for modulus 5, ignored for modulus 6.
        nine_b = 1'b1;
        wait_cyc(10);
        check(q_bcd, 4'd9, "R9 nine bcd");
        check(q_bq, 4'd9, "R9 nine bq");
        check(q_m12, 4'd0, "R9 nine ignored m12");
        // R10: counting edges have no effect under the nine override.
        pulse(0);
        check(q_bcd, 4'd9, "R10 nine holds through edge");
        // R10: nine wins over clear; clear still acts on modulus 6.
        pulse(2);
        clr_a = 1'b1;
        clr_b = 1'b1;
        wait_cyc(10);
        check(q_bcd, 4'd9, "R10 nine over clear");
        check(q_m12, 4'd0, "R10 clear acts when nine ignored");
        clr_a = 1'b0;
        clr_b = 1'b0;
        nine_a = 1'b0;
        nine_b = 1'b0;
        wait_cyc(10);
        // R4: from nine the next edge wraps to zero.
        pulse(0);
        check(q_bcd, 4'd0, "R4 wrap from preset nine");
        pulse(0);
        check(q_bcd, 4'd1, "R4 count resumes");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule